// File: doc/BRIEF.md
# Indexed Register Front End for an Interrupt Routing Controller

This block is the software-visible register file of an I/O interrupt routing controller. The bus does not see the internal registers directly. Software first writes an internal index into a select register. It then reads or writes the chosen register through a single data window. The internal space holds four things: a controller identity, a read-only version word, an arbitration identity, and a table of routing entries. Each routing entry is 64 bits wide and is reached as two 32-bit halves at neighbouring indices.

Every bus request completes in the cycle after it is presented. It produces a registered response with read data and an error flag. Only full 32-bit accesses to the select offset or the window offset are legal. Anything else is refused with an error and changes nothing. A window access to an index that names no register does not fail on the bus. Instead it raises a one-cycle warning strobe.

Top module: `irq_route_regs`

## Requirements
- R1: Every request presented with `bus_valid` high produces `rsp_valid` high in the following cycle, and no response appears without a request.
- R2: A request whose size code is not 2 (32-bit) or whose offset is neither 0x00 nor 0x10 returns `rsp_err`=1 and read data 0, and leaves all internal state unchanged.
- R3: A 32-bit write at offset 0x00 loads the 8-bit select register from data bits 7:0. A read at offset 0x00 returns the select value zero-extended.
- R4: Index 0x00 holds the 4-bit controller identity. A window write takes it from data bits 27:24, and a read returns it in bits 27:24 with every other bit zero.
- R5: Index 0x01 reads as (ENTRIES-1) in bits 23:16 ORed with the version code in bits 7:0. That is 0x00170011 with the defaults. Writes to it have no effect.
- R6: Index 0x02 holds the 4-bit arbitration identity, written from and read in bits 27:24.
- R7: Routing entry i has its low word at index 0x10+2i and its high word at index 0x10+2i+1, for i from 0 to ENTRIES-1.
- R8: A write to a low word keeps only bits 0-11, 13, 15 and 16 (mask 0x0001AFFF). A write to a high word keeps only bits 31:24 (mask 0xFF000000). All other bits read back as zero.
- R9: After reset the select register is 0, both identities equal INIT_ID, every low word reads 0x00010000 (mask bit 16 set), and every high word reads 0.
- R10: A window access to any other index (0x03-0x0F, or 0x10+2·ENTRIES and above) reads 0 and ignores writes. It raises `idx_warn` for exactly the response cycle, with `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code; 2 = 32-bit, others illegal |
| bus_addr | input | AW (8) | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Request was illegal |
| idx_warn | output | 1 | Window access hit an undefined index |

## Verification
The select register is updated at the same clock edge that produces the response of the request that wrote it. A window access issued in the very next cycle must therefore decode the new index. The bench issues select writes and window accesses back to back with no idle cycle, sweeping every one of the 256 index values. It judges each window response against a value it computes arithmetically from the index, the pattern written and the scrub masks. Write-then-read pairs on the same entry half in adjacent cycles confirm that the table update and the next read decode do not race.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam logic [1:0]  SZ_WORD  = 2'd2;
   localparam int unsigned OFF_SEL  = 0;
   localparam int unsigned OFF_WIN  = 16;
   localparam int unsigned IDX_ID   = 0;
   localparam int unsigned IDX_VER  = 1;
   localparam int unsigned IDX_ARB  = 2;
   localparam int unsigned IDX_TBL  = 16;
   localparam int unsigned ID_LSB   = 24;
   localparam int unsigned MASK_BIT = 16;
   localparam logic [WORD_W-1:0] LO_KEEP = 32'h0001_AFFF;
   localparam logic [WORD_W-1:0] HI_KEEP = 32'hFF00_0000;

   typedef enum logic [2:0] {
      K_ID, K_VER, K_ARB, K_TBL, K_NONE
   } reg_kind_t;
endpackage

// File: rtl/irq_index_decode.sv
module irq_index_decode
   import irq_regs_pkg::*;
#(
   parameter int unsigned ENTRIES = 24,
   parameter int unsigned SEL_W   = 8,
   localparam int unsigned EW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [SEL_W-1:0] idx,
   output reg_kind_t        kind,
   output logic [EW-1:0]    ent,
   output logic             hi
);
   localparam int unsigned TBL_END = IDX_TBL + 2 * ENTRIES;

   logic [SEL_W-1:0] rel;
   assign rel = idx - SEL_W'(IDX_TBL);

   always_comb begin
      kind = K_NONE;
      ent  = '0;
      hi   = 1'b0;
      if (int'(idx) == IDX_ID)       kind = K_ID;
      else if (int'(idx) == IDX_VER) kind = K_VER;
      else if (int'(idx) == IDX_ARB) kind = K_ARB;
      else if (int'(idx) >= IDX_TBL && int'(idx) < TBL_END) begin
         kind = K_TBL;
         ent  = EW'(rel >> 1);
         hi   = idx[0];
      end
   end
endmodule

// File: rtl/irq_redir_store.sv
module irq_redir_store
   import irq_regs_pkg::*;
#(
   parameter int unsigned ENTRIES = 24,
   parameter bit          SCRUB   = 1'b1,
   localparam int unsigned EW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [EW-1:0]     ent,
   input  logic              hi,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   localparam logic [WORD_W-1:0] LO_RST = WORD_W'(1) << MASK_BIT;

   logic [WORD_W-1:0] lo_arr [ENTRIES];
   logic [WORD_W-1:0] hi_arr [ENTRIES];
   logic [WORD_W-1:0] lo_in, hi_in;

   generate
      if (SCRUB) begin : g_scrub
         assign lo_in = wdata & LO_KEEP;
         assign hi_in = wdata & HI_KEEP;
      end else begin : g_raw
         assign lo_in = wdata;
         assign hi_in = wdata;
      end
   endgenerate

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         logic [WORD_W-1:0] lo_q, hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= LO_RST;
               hi_q <= '0;
            end else if (we && int'(ent) == i) begin
               if (hi) hi_q <= hi_in;
               else    lo_q <= lo_in;
            end
         end
         assign lo_arr[i] = lo_q;
         assign hi_arr[i] = hi_q;
      end
   endgenerate

   assign rdata = hi ? hi_arr[ent] : lo_arr[ent];

   // R8: a stored word never shows a reserved bit
   p_scrub_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !SCRUB || ((hi ? (rdata & ~HI_KEEP) : (rdata & ~LO_KEEP)) == '0));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_regs_pkg::*;
#(
   parameter int unsigned ENTRIES = 24,
   parameter int unsigned SEL_W   = 8,
   parameter int unsigned AW      = 8,
   parameter int unsigned ID_W    = 4,
   parameter logic [7:0]  VERSION = 8'h11,
   parameter logic [3:0]  INIT_ID = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [1:0]        bus_size,
   input  logic [AW-1:0]     bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              idx_warn
);
   localparam int unsigned EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [WORD_W-1:0] VER_WORD =
      (WORD_W'(ENTRIES - 1) << 16) | WORD_W'(VERSION);

   initial begin : elab_chk
      if (ENTRIES < 1 || IDX_TBL + 2 * ENTRIES > (1 << SEL_W))
         $fatal(1, "ENTRIES does not fit the index space");
      if (ID_W != 4 || SEL_W < 6 || SEL_W > WORD_W || AW < 5)
         $fatal(1, "unsupported width parameters");
   end

   logic [SEL_W-1:0] sel_q;
   logic [ID_W-1:0]  id_q, arb_q;
   reg_kind_t        kind;
   logic [EW-1:0]    ent;
   logic             hi;
   logic [WORD_W-1:0] tbl_rd, win_rd;
   logic legal, sel_acc, win_acc, tbl_we;

   assign legal   = (bus_size == SZ_WORD) &&
                    (int'(bus_addr) == OFF_SEL || int'(bus_addr) == OFF_WIN);
   assign sel_acc = bus_valid && legal && int'(bus_addr) == OFF_SEL;
   assign win_acc = bus_valid && legal && int'(bus_addr) == OFF_WIN;
   assign tbl_we  = win_acc && bus_write && kind == K_TBL;

   irq_index_decode #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_dec (
      .idx(sel_q), .kind(kind), .ent(ent), .hi(hi)
   );

   irq_redir_store #(.ENTRIES(ENTRIES), .SCRUB(1'b1)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .ent(ent), .hi(hi),
      .wdata(bus_wdata), .rdata(tbl_rd)
   );

   always_comb begin
      case (kind)
         K_ID:    win_rd = WORD_W'(id_q) << ID_LSB;
         K_VER:   win_rd = VER_WORD;
         K_ARB:   win_rd = WORD_W'(arb_q) << ID_LSB;
         K_TBL:   win_rd = tbl_rd;
         default: win_rd = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= INIT_ID;
         arb_q <= INIT_ID;
      end else begin
         if (sel_acc && bus_write) sel_q <= bus_wdata[SEL_W-1:0];
         if (win_acc && bus_write && kind == K_ID)
            id_q <= bus_wdata[ID_LSB +: ID_W];
         if (win_acc && bus_write && kind == K_ARB)
            arb_q <= bus_wdata[ID_LSB +: ID_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         idx_warn  <= 1'b0;
      end else begin
         rsp_valid <= bus_valid;
         rsp_err   <= bus_valid && !legal;
         idx_warn  <= win_acc && kind == K_NONE;
         if (sel_acc && !bus_write)      rsp_rdata <= WORD_W'(sel_q);
         else if (win_acc && !bus_write) rsp_rdata <= win_rd;
         else                            rsp_rdata <= '0;
      end
   end

   // R1: one response per request, one cycle later
   p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> rsp_valid);
   p_no_stray_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !rsp_valid);
   // R2: illegal request is flagged and returns zero
   p_err_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && (bus_size != SZ_WORD)) |=> (rsp_err && rsp_rdata == '0));
   // R3: select only moves on a legal select write
   p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_acc && bus_write) |=> $stable(sel_q));
   // R10: warning is a valid, non-error response
   p_warn_noerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idx_warn |-> (rsp_valid && !rsp_err && rsp_rdata == '0));
endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
   localparam int unsigned N   = 24;
   localparam logic [3:0]  IID = 4'h6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [1:0]  bus_size = 2'd2;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        rsp_valid, rsp_err, idx_warn;
   logic [31:0] rsp_rdata;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_route_regs #(.ENTRIES(N), .INIT_ID(IID)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .idx_warn(idx_warn)
   );

   logic [31:0] r_data; logic r_err, r_warn, r_vld;

   task automatic acc(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                      input logic [31:0] d);
      bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0;
      r_data = rsp_rdata; r_err = rsp_err; r_warn = idx_warn; r_vld = rsp_valid;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lo_pat(int i);
      return {8'(i * 5 + 1), 8'(~i), 8'(i * 3), 8'(i * 7 + 1)} ^ ((i % 2) ? 32'h0001_0000 : 32'h0);
   endfunction
   function automatic logic [31:0] hi_pat(int i);
      return {8'(i + 8'h40), 24'hC3_5A_FF};
   endfunction

   logic [3:0] id_exp, arb_exp;
   bit wrote;

   function automatic logic [31:0] exp_idx(int x);
      if (x == 0) return {4'h0, id_exp, 24'h0};
      if (x == 1) return 32'h0017_0011;
      if (x == 2) return {4'h0, arb_exp, 24'h0};
      if (x >= 16 && x < 16 + 2 * N) begin
         if (!wrote) return (x % 2) ? 32'h0 : 32'h0001_0000;
         return (x % 2) ? (hi_pat((x - 16) / 2) & 32'hFF00_0000)
                        : (lo_pat((x - 16) / 2) & 32'h0001_AFFF);
      end
      return 32'h0;
   endfunction

   task automatic sweep(input string req);
      for (int x = 0; x < 256; x++) begin
         acc(1, 2'd2, 8'h00, 32'(x));
         acc(0, 2'd2, 8'h10, 32'h0);
         chk(req, r_data, exp_idx(x));
         chk("R10 warn", {31'h0, r_warn}, {31'h0, !(x <= 2 || (x >= 16 && x < 16 + 2 * N))});
         chk("R10 noerr", {31'h0, r_err}, 32'h0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      id_exp = IID; arb_exp = IID; wrote = 0;
      // R9 reset state
      chk("R1 idle", {31'h0, rsp_valid}, 32'h0);
      acc(0, 2'd2, 8'h00, 32'h0);
      chk("R9 select", r_data, 32'h0);
      chk("R1 valid", {31'h0, r_vld}, 32'h1);
      sweep("R9 reset sweep");
      // R3 select read back
      acc(1, 2'd2, 8'h00, 32'h0000_01A7);
      acc(0, 2'd2, 8'h00, 32'h0);
      chk("R3 select", r_data, 32'h0000_00A7);
      // R7 R8 write every half back to back with readback
      for (int i = 0; i < int'(N); i++) begin
         acc(1, 2'd2, 8'h00, 32'(16 + 2 * i));
         acc(1, 2'd2, 8'h10, lo_pat(i));
         acc(0, 2'd2, 8'h10, 32'h0);
         chk("R8 low scrub", r_data, lo_pat(i) & 32'h0001_AFFF);
         acc(1, 2'd2, 8'h00, 32'(17 + 2 * i));
         acc(1, 2'd2, 8'h10, hi_pat(i));
         acc(0, 2'd2, 8'h10, 32'h0);
         chk("R8 high scrub", r_data, hi_pat(i) & 32'hFF00_0000);
      end
      wrote = 1;
      // R4 R6 identities, R5 version write ignored
      acc(1, 2'd2, 8'h00, 32'h0); acc(1, 2'd2, 8'h10, 32'hF9FF_FFFF); id_exp = 4'h9;
      acc(1, 2'd2, 8'h00, 32'h2); acc(1, 2'd2, 8'h10, 32'h5A00_0000); arb_exp = 4'hA;
      acc(1, 2'd2, 8'h00, 32'h1); acc(1, 2'd2, 8'h10, 32'hFFFF_FFFF);
      acc(0, 2'd2, 8'h10, 32'h0);
      chk("R5 version", r_data, 32'h0017_0011);
      // R10 write to undefined indices, incl. just past the table
      acc(1, 2'd2, 8'h00, 32'(16 + 2 * N)); acc(1, 2'd2, 8'h10, 32'hFFFF_FFFF);
      chk("R10 write warn", {31'h0, r_warn}, 32'h1);
      acc(1, 2'd2, 8'h00, 32'h7); acc(1, 2'd2, 8'h10, 32'hFFFF_FFFF);
      // R2 illegal accesses change nothing
      acc(1, 2'd2, 8'h00, 32'h10);
      acc(1, 2'd0, 8'h10, 32'hFFFF_FFFF);
      chk("R2 err size", {31'h0, r_err}, 32'h1);
      acc(1, 2'd1, 8'h00, 32'h3);
      chk("R2 err size sel", {31'h0, r_err}, 32'h1);
      acc(0, 2'd2, 8'h04, 32'h0);
      chk("R2 err offset", {31'h0, r_err}, 32'h1);
      chk("R2 rdata zero", r_data, 32'h0);
      acc(1, 2'd2, 8'h14, 32'h0);
      chk("R2 err offset wr", {31'h0, r_err}, 32'h1);
      acc(0, 2'd2, 8'h00, 32'h0);
      chk("R2 select kept", r_data, 32'h10);
      acc(0, 2'd2, 8'h10, 32'h0);
      chk("R2 entry kept", r_data, lo_pat(0) & 32'h0001_AFFF);
      // R4 R6 R7 R10 full sweep after writes
      sweep("R4 R6 R7 R10 sweep");
      // R9 reset again restores defaults
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      id_exp = IID; arb_exp = IID; wrote = 0;
      sweep("R9 re-reset sweep");
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin repeat (100000) @(posedge clk); checks++; errors++;
               $display("FAIL watchdog actual=hung expected=finish"); end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule